// File: doc/BRIEF.md
# Multi-Setting Digital Input Glitch Filter Bank

This block cleans up a set of asynchronous digital input lines before they reach the rest of the chip. Each line first passes through a two-flop synchronizer on the filter clock. A per-channel counter then holds back any change of level until the line has been seen at the new level on a run of consecutive samples. If the line slips back to the old level before the run completes, the run restarts from zero. Rising and falling edges are qualified in the same way.

Every channel has a 2-bit mode input. The modes are: off, with the output following the synchronized line; short, with a 5-sample run; medium, with a 257-sample run; and long. In long mode the counter advances only on a tick from one shared prescaler, so a run of about a hundred thousand clocks needs only a small counter. The price is output jitter of up to one tick. A direct-route flag per channel sends the synchronized, unfiltered line to the output whatever the mode.

At the default parameters and a 40 MHz clock, short mode passes 125 ns and rejects 100 ns. Medium mode passes 6.425 µs and rejects 6.400 µs. Long mode (254 ticks of 400 clocks) passes 2.54 ms and rejects 2.53 ms.

Top module: `glitch_filter_bank`

## Requirements
- R1: While reset is held and on the first cycle after it, every bit of `clean_out` is 0. Filter state resets to level 0 and mode memory resets to off.
- R2: With mode 2'b00 (off) and no direct route, `clean_out` follows `raw_in` two clock edges after a change, with no qualification. A one-cycle pulse appears at the output.
- R3: In mode 2'b01 (short), the output takes a new level only after SHORT_N (5) consecutive samples at that level. A 5-sample pulse passes and a 4-sample pulse is rejected.
- R4: In mode 2'b10 (medium), the run length is MED_N (257). A 257-sample pulse passes and a 256-sample pulse is rejected.
- R5: In mode 2'b11 (long), the counter advances only on prescaler ticks, one every PRESCALE clocks. A pulse of LONG_TICKS*PRESCALE samples always passes. A pulse of (LONG_TICKS-1)*PRESCALE samples never passes.
- R6: A sample at the old level during a run restarts the count. In short mode, 4 high, 1 low, 4 high never reaches the output.
- R7: When `direct_route[i]` is 1, `clean_out[i]` equals the synchronized input of channel i in every mode.
- R8: The mode and route of each channel, in field `mode_sel[2i+1:2i]`, affect only channel i.
- R9: A change of a channel's mode clears that channel's run count. Samples counted before the change do not shorten the run needed afterwards.
- R10: Falling edges are qualified like rising ones. The filtered level never moves while the synchronized input equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_filt | input | 1 | Filter sample clock (40 MHz nominal) |
| rst_filt | input | 1 | Synchronous active-high reset |
| raw_in | input | NUM_CH | Asynchronous input lines |
| mode_sel | input | 2*NUM_CH | Per-channel mode: 00 off, 01 short, 10 medium, 11 long |
| direct_route | input | NUM_CH | Per-channel unfiltered path select |
| clean_out | output | NUM_CH | Filtered (or routed) lines |

## Verification
The bench drives pulses one sample either side of each guaranteed pass and reject width in every mode. A counter compared with the wrong end of the run would let the short pulse through or hold back the long one. Long mode is run with a small prescaler, and the pulse widths are chosen so that the outcome does not depend on the tick phase. A design that counted every clock in long mode would pass the reject pulse. Glitch-restart and mode-change cases catch a counter that keeps stale counts: such a design would pass the split pulse, or would release the output well before a full run in the new mode. Mixed settings on neighbouring channels expose field decoding that crosses channel boundaries.

// File: rtl/gfb_pkg.sv
package gfb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_MED   = 2'b10,
    MODE_LONG  = 2'b11
  } gf_mode_e;

  // Number of qualifying samples a mode needs before the output moves.
  function automatic int unsigned run_target(gf_mode_e m, int unsigned short_n,
                                             int unsigned med_n, int unsigned long_t);
    case (m)
      MODE_SHORT: return short_n;
      MODE_MED:   return med_n;
      MODE_LONG:  return long_t;
      default:    return 1;
    endcase
  endfunction

  // Whether this cycle counts as a sample for the given mode.
  function automatic logic sample_strobe(gf_mode_e m, logic tick);
    return (m == MODE_LONG) ? tick : 1'b1;
  endfunction
endpackage

// File: rtl/gfb_sync.sv
module gfb_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gfb_prescaler.sv
module gfb_prescaler #(
  parameter int unsigned PRESCALE = 400
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = $clog2(PRESCALE + 1);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)               div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/gfb_channel.sv
module gfb_channel
  import gfb_pkg::*;
#(
  parameter int unsigned SHORT_N    = 5,
  parameter int unsigned MED_N      = 257,
  parameter int unsigned LONG_TICKS = 254
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp,
  input  logic [1:0] mode,
  input  logic       route,
  input  logic       tick,
  output logic       filt,
  output logic       out
);
  localparam int unsigned MAXN = (MED_N > LONG_TICKS) ? MED_N : LONG_TICKS;
  localparam int unsigned CW   = $clog2(MAXN + 1);

  gf_mode_e      m;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] target;
  logic          mode_chg;
  logic          mismatch;
  logic          strobe;
  logic          filt_q;

  assign m        = gf_mode_e'(mode);
  assign target   = CW'(run_target(m, SHORT_N, MED_N, LONG_TICKS) - 1);
  assign mode_chg = (mode != mode_q);
  assign mismatch = (smp != filt_q);
  assign strobe   = sample_strobe(m, tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      mode_q <= mode;
      if (m == MODE_OFF) begin
        filt_q <= smp;
        cnt_q  <= '0;
      end else if (mode_chg || !mismatch) begin
        cnt_q <= '0;
      end else if (strobe) begin
        if (cnt_q == target) begin
          filt_q <= smp;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign filt = filt_q;
  assign out  = (route || m == MODE_OFF) ? smp : filt_q;
endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned SHORT_N    = 5,
  parameter int unsigned MED_N      = 257,
  parameter int unsigned LONG_TICKS = 254,
  parameter int unsigned PRESCALE   = 400
) (
  input  logic                  clk_filt,
  input  logic                  rst_filt,
  input  logic [NUM_CH-1:0]     raw_in,
  input  logic [2*NUM_CH-1:0]   mode_sel,
  input  logic [NUM_CH-1:0]     direct_route,
  output logic [NUM_CH-1:0]     clean_out
);
  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] filt_lvl;
  logic              long_tick;

  gfb_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk(clk_filt), .rst(rst_filt), .async_in(raw_in), .sync_out(sync_lvl)
  );

  gfb_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk_filt), .rst(rst_filt), .tick(long_tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    gfb_channel #(
      .SHORT_N(SHORT_N), .MED_N(MED_N), .LONG_TICKS(LONG_TICKS)
    ) u_ch (
      .clk  (clk_filt),
      .rst  (rst_filt),
      .smp  (sync_lvl[i]),
      .mode (mode_sel[2*i +: 2]),
      .route(direct_route[i]),
      .tick (long_tick),
      .filt (filt_lvl[i]),
      .out  (clean_out[i])
    );
  end
endmodule

// File: rtl/gfb_chk.sv
module gfb_chk #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned PRESCALE = 400
) (
  input logic                clk,
  input logic                rst,
  input logic [2*NUM_CH-1:0] mode_sel,
  input logic [NUM_CH-1:0]   direct_route,
  input logic [NUM_CH-1:0]   sync_lvl,
  input logic [NUM_CH-1:0]   filt_lvl,
  input logic [NUM_CH-1:0]   clean_out,
  input logic                tick
);
  logic        rst_d;
  logic        tick_seen;
  int unsigned gap;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      gap       <= 0;
      tick_seen <= 1'b0;
    end else if (tick) begin
      gap       <= 0;
      tick_seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  // R1: outputs low while reset has been applied for an edge
  always @(negedge clk) begin
    if (rst && rst_d) begin
      p_reset_low_r1: assert (clean_out == '0);
    end
  end

  // R5: long-mode ticks are exactly PRESCALE clocks apart
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && tick_seen) |-> (gap == PRESCALE - 1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_route_r7: assert property (@(posedge clk) disable iff (rst)
      direct_route[i] |-> (clean_out[i] == sync_lvl[i]));

    p_off_track_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_sel[2*i +: 2] == 2'b00) |=> (filt_lvl[i] == $past(sync_lvl[i])));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (sync_lvl[i] == filt_lvl[i]) |=> (filt_lvl[i] == $past(filt_lvl[i])));

    p_short_run_r3: assert property (@(posedge clk) disable iff (rst)
      ((filt_lvl[i] != $past(filt_lvl[i])) && (mode_sel[2*i +: 2] == 2'b01) &&
       ($past(mode_sel[2*i +: 2], 5) == 2'b01)) |->
      (($past(sync_lvl[i], 1) == filt_lvl[i]) && ($past(sync_lvl[i], 2) == filt_lvl[i]) &&
       ($past(sync_lvl[i], 3) == filt_lvl[i]) && ($past(sync_lvl[i], 4) == filt_lvl[i]) &&
       ($past(sync_lvl[i], 5) == filt_lvl[i])));
  end
endmodule

bind glitch_filter_bank gfb_chk #(.NUM_CH(NUM_CH), .PRESCALE(PRESCALE)) u_gfb_chk (
  .clk(clk_filt), .rst(rst_filt), .mode_sel(mode_sel), .direct_route(direct_route),
  .sync_lvl(sync_lvl), .filt_lvl(filt_lvl), .clean_out(clean_out), .tick(long_tick)
);

// File: tb/test_glitch_filter_bank.sv
module test_glitch_filter_bank;
  localparam int unsigned NCH = 3;
  localparam int unsigned PS  = 4;
  localparam int unsigned LT  = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] raw = '0;
  logic [2*NCH-1:0] mode = '0;
  logic [NCH-1:0] route = '0;
  logic [NCH-1:0] dout;
  logic [NCH-1:0] seen_hi = '0;
  logic [NCH-1:0] seen_lo = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  glitch_filter_bank #(
    .NUM_CH(NCH), .SHORT_N(5), .MED_N(257), .LONG_TICKS(LT), .PRESCALE(PS)
  ) i_glitch_filter_bank (
    .clk_filt(clk), .rst_filt(rst), .raw_in(raw), .mode_sel(mode),
    .direct_route(route), .clean_out(dout)
  );

  always @(negedge clk) begin
    seen_hi <= seen_hi | dout;
    seen_lo <= seen_lo | ~dout;
  end

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] w;
    logic        pass;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'b01, 16'd5,   1'b1, 4'd3},  // R3 short pass
    '{2'b01, 16'd4,   1'b0, 4'd3},  // R3 short reject
    '{2'b10, 16'd257, 1'b1, 4'd4},  // R4 medium pass
    '{2'b10, 16'd256, 1'b0, 4'd4},  // R4 medium reject
    '{2'b11, 16'd20,  1'b1, 4'd5},  // R5 long pass = LT*PS
    '{2'b11, 16'd16,  1'b0, 4'd5},  // R5 long reject = (LT-1)*PS
    '{2'b00, 16'd1,   1'b1, 4'd2},  // R2 off passes a single sample
    '{2'b01, 16'd12,  1'b1, 4'd3},  // R3 short, wide pulse
    '{2'b11, 16'd12,  1'b0, 4'd5}   // R5 long, well short of a run
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_seen();
    @(negedge clk);
    seen_hi = '0;
    seen_lo = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] mask, input int w);
    raw = raw | mask;
    repeat (w) @(negedge clk);
    raw = raw & ~mask;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset", 32'(dout), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", 32'(dout), 0);

    // table walk on channel 0
    foreach (VEC[k]) begin
      mode[1:0] = VEC[k].md;
      repeat (3) @(negedge clk);
      clr_seen();
      pulse(3'b001, int'(VEC[k].w));
      repeat (400) @(negedge clk);
      check($sformatf("R%0d vec%0d pass", VEC[k].req, k), 32'(seen_hi[0]), 32'(VEC[k].pass));
      check($sformatf("R%0d vec%0d settle", VEC[k].req, k), 32'(dout[0]), 0);
    end

    // R2 latency in off mode
    mode = '0;
    repeat (3) @(negedge clk);
    raw[1] = 1'b1;
    @(negedge clk);
    check("R2 one edge", 32'(dout[1]), 0);
    @(negedge clk);
    check("R2 two edges", 32'(dout[1]), 1);
    raw[1] = 1'b0;
    repeat (5) @(negedge clk);

    // R6 glitch restarts the run in short mode
    mode[1:0] = 2'b01;
    repeat (3) @(negedge clk);
    clr_seen();
    pulse(3'b001, 4);
    @(negedge clk);
    pulse(3'b001, 4);
    repeat (20) @(negedge clk);
    check("R6 split pulse", 32'(seen_hi[0]), 0);

    // R10 falling edge qualified: high, 4-low glitch, high, then real low
    pulse(3'b000, 0);
    raw[0] = 1'b1;
    repeat (12) @(negedge clk);
    check("R10 rose", 32'(dout[0]), 1);
    clr_seen();
    raw[0] = 1'b0;
    repeat (4) @(negedge clk);
    raw[0] = 1'b1;
    repeat (12) @(negedge clk);
    check("R10 low glitch rejected", 32'(seen_lo[0]), 0);
    raw[0] = 1'b0;
    repeat (12) @(negedge clk);
    check("R10 fell", 32'(dout[0]), 0);

    // R8 independent channels: ch0 short, ch1 off, ch2 long
    mode = {2'b11, 2'b00, 2'b01};
    repeat (3) @(negedge clk);
    clr_seen();
    pulse(3'b111, 3);
    repeat (60) @(negedge clk);
    check("R8 width3", 32'(seen_hi), 32'(3'b010));
    clr_seen();
    pulse(3'b111, 6);
    repeat (60) @(negedge clk);
    check("R8 width6", 32'(seen_hi), 32'(3'b011));

    // R7 direct route bypasses medium filter
    mode = {2'b10, 2'b00, 2'b00};
    route = 3'b100;
    repeat (3) @(negedge clk);
    clr_seen();
    pulse(3'b100, 1);
    repeat (5) @(negedge clk);
    check("R7 routed pulse", 32'(seen_hi[2]), 1);
    route = '0;
    repeat (3) @(negedge clk);

    // R9 mode change clears the count: 2 short samples, then switch to long
    mode[1:0] = 2'b01;
    repeat (3) @(negedge clk);
    raw[0] = 1'b1;
    repeat (4) @(negedge clk);
    mode[1:0] = 2'b11;
    repeat (14) @(negedge clk);
    check("R9 no early release", 32'(dout[0]), 0);
    repeat (26) @(negedge clk);
    check("R9 full run release", 32'(dout[0]), 1);
    raw[0] = 1'b0;
    repeat (40) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule